// File: doc/BRIEF.md
# Read/Write Drain Mode Scheduler

This block sits beside the command scheduler of a single-channel memory controller and decides, slot by slot, whether the controller should be serving its read queue or its write queue. It watches the occupancy counts of both queues and a one-cycle pulse that marks each burst sent to the memory. From these it produces a mode bit, a one-cycle switch pulse that marks each change of direction, and a blocked flag that stays high while the data bus turnaround gap is still running.

Writes are drained with hysteresis. A nearly full write queue forces write mode even while reads wait. A half-full write queue starts a drain only when no read is pending. Once draining, the block keeps serving writes until a minimum number of write bursts has gone out, unless the write queue runs dry first. Read-to-write and write-to-read turnarounds have separate gap lengths. Inside a gap, burst pulses are not counted and no direction decision is made.

Top module: `rw_drain_sched`

## Requirements
- R1: The switch thresholds are whole entry counts, each rounded up from its percentage of write-queue capacity. With the default settings the high mark is 55 entries and the low mark is 32 entries.
- R2: In read mode, when not blocked and write occupancy is at least the high mark, the mode bit is 1 (write) after the next clock edge, even when reads are pending.
- R3: In read mode, when not blocked, the read count is 0 and write occupancy is at least the low mark, the mode bit becomes 1 after the next edge.
- R4: In read mode, when write occupancy is below the high mark and either reads are pending or write occupancy is below the low mark, the mode bit stays 0 and no switch pulse appears.
- R5: In write mode, when not blocked, the block returns to read mode (mode bit 0) after the next edge in either of two cases: the write count is 0, or at least 16 write bursts have been counted since entry and either the read count is non-zero or write occupancy is below the low mark. In every other case it stays in write mode.
- R6: The switch pulse is high for exactly one cycle, and that is the cycle in which the mode bit takes its new value.
- R7: The blocked flag rises in the same cycle as the switch pulse. It stays high for 2 cycles after a read-to-write switch and for 6 cycles after a write-to-read switch.
- R8: While blocked is high, burst pulses are not counted toward the write minimum and the mode bit does not change.
- R9: Synchronous reset puts the block in read mode (mode bit 0), with switch pulse 0, blocked 0 and all counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_count | input | 6 | Read-queue occupancy |
| wr_count | input | 7 | Write-queue occupancy |
| burst_issued | input | 1 | One-cycle pulse per burst sent to memory |
| mode_write | output | 1 | 1 = serve writes, 0 = serve reads |
| switch_pulse | output | 1 | One-cycle pulse marking a change of direction |
| blocked | output | 1 | Turnaround gap in progress |

## Verification
The assertions check several rules on every cycle. Each switch pulse coincides with a flip of the mode bit and with blocked being high. No switch follows a blocked cycle. The high mark always forces write mode. Every fall back to read mode is justified either by an empty write queue or by the write minimum having been met. Other behaviour can only be shown by the bench's scenarios. These are the exact boundaries 31/32 and 54/55. They also include the gap lengths of 2 and 6 cycles, the fact that bursts inside a gap do not count toward the minimum of 16, continued draining past 16 when the queue is still above the low mark with no reads, and reset from write mode.

// File: rtl/rw_drain_pkg.sv
package rw_drain_pkg;

    typedef enum logic {
        MODE_RD = 1'b0,
        MODE_WR = 1'b1
    } dir_e;

    typedef struct packed {
        logic hi_hit;
        logic lo_hit;
        logic rd_empty;
        logic wr_empty;
    } occ_flags_t;

    function automatic int unsigned pct_ceil(input int unsigned cap, input int unsigned pct);
        return (cap * pct + 99) / 100;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drain_thresh.sv
module drain_thresh
    import rw_drain_pkg::*;
#(
    parameter int unsigned RD_W   = 6,
    parameter int unsigned WR_W   = 7,
    parameter int unsigned HI_LVL = 55,
    parameter int unsigned LO_LVL = 32
) (
    input  logic [RD_W-1:0] rd_count,
    input  logic [WR_W-1:0] wr_count,
    output occ_flags_t      flags
);
    localparam logic [WR_W-1:0] HI_V = WR_W'(HI_LVL);
    localparam logic [WR_W-1:0] LO_V = WR_W'(LO_LVL);

    always_comb begin
        flags.hi_hit   = (wr_count >= HI_V);
        flags.lo_hit   = (wr_count >= LO_V);
        flags.rd_empty = (rd_count == '0);
        flags.wr_empty = (wr_count == '0);
    end

    always_comb begin
        a_r1_marks_ordered: assert (HI_LVL >= LO_LVL || $isunknown(wr_count) || 1'b1 == (HI_LVL >= LO_LVL));
    end
endmodule

// File: rtl/turnaround_timer.sv
module turnaround_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    a_r7_no_reload_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load);
endmodule

// File: rtl/drain_mode_fsm.sv
module drain_mode_fsm
    import rw_drain_pkg::*;
#(
    parameter int unsigned MIN_WR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  occ_flags_t flags,
    input  logic       burst,
    input  logic       blocked,
    output dir_e       mode,
    output logic       sw_q,
    output logic       go_wr,
    output logic       go_rd
);
    localparam int unsigned DONE_W = $clog2(MIN_WR + 1);
    localparam logic [DONE_W-1:0] MIN_V = DONE_W'(MIN_WR);

    dir_e              mode_q;
    logic [DONE_W-1:0] done_q;
    logic              min_met;

    assign min_met = (done_q >= MIN_V);

    always_comb begin
        go_wr = 1'b0;
        go_rd = 1'b0;
        if (!blocked) begin
            if (mode_q == MODE_RD)
                go_wr = flags.hi_hit || (flags.rd_empty && flags.lo_hit);
            else
                go_rd = flags.wr_empty || (min_met && (!flags.rd_empty || !flags.lo_hit));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RD;
            done_q <= '0;
            sw_q   <= 1'b0;
        end else begin
            sw_q <= go_wr || go_rd;
            if (go_wr) begin
                mode_q <= MODE_WR;
                done_q <= '0;
            end else if (go_rd) begin
                mode_q <= MODE_RD;
                done_q <= '0;
            end else if (mode_q == MODE_WR && burst && !blocked && !min_met) begin
                done_q <= done_q + 1'b1;
            end
        end
    end

    assign mode = mode_q;

    a_r6_pulse_flips_mode: assert property (@(posedge clk) disable iff (rst)
        sw_q |-> (mode_q != $past(mode_q)));
    a_r8_blocked_holds: assert property (@(posedge clk) disable iff (rst)
        blocked |=> (mode_q == $past(mode_q)));
    a_r2_high_forces_write: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RD && !blocked && flags.hi_hit) |=> (mode_q == MODE_WR));
    a_r5_leave_justified: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WR && !go_rd) |=> (mode_q == MODE_WR));
    a_r5_min_or_empty: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WR && !blocked && !flags.wr_empty && done_q < MIN_V) |=> (mode_q == MODE_WR));
endmodule

// File: rtl/rw_drain_sched.sv
module rw_drain_sched
    import rw_drain_pkg::*;
#(
    parameter int unsigned RD_DEPTH = 32,
    parameter int unsigned WR_DEPTH = 64,
    parameter int unsigned HI_PCT   = 85,
    parameter int unsigned LO_PCT   = 50,
    parameter int unsigned MIN_WR   = 16,
    parameter int unsigned WTR_CYC  = 6,
    parameter int unsigned RTW_CYC  = 2,
    localparam int unsigned RD_W    = $clog2(RD_DEPTH + 1),
    localparam int unsigned WR_W    = $clog2(WR_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RD_W-1:0] rd_count,
    input  logic [WR_W-1:0] wr_count,
    input  logic            burst_issued,
    output logic            mode_write,
    output logic            switch_pulse,
    output logic            blocked
);
    localparam int unsigned HI_LVL = pct_ceil(WR_DEPTH, HI_PCT);
    localparam int unsigned LO_LVL = pct_ceil(WR_DEPTH, LO_PCT);
    localparam int unsigned TA_W   = $clog2(max2(WTR_CYC, RTW_CYC) + 1);

    occ_flags_t flags;
    dir_e       mode;
    logic       go_wr;
    logic       go_rd;
    logic       sw_q;
    logic       busy;

    drain_thresh #(
        .RD_W  (RD_W),
        .WR_W  (WR_W),
        .HI_LVL(HI_LVL),
        .LO_LVL(LO_LVL)
    ) u_thresh (
        .rd_count(rd_count),
        .wr_count(wr_count),
        .flags   (flags)
    );

    drain_mode_fsm #(
        .MIN_WR(MIN_WR)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .burst  (burst_issued),
        .blocked(busy),
        .mode   (mode),
        .sw_q   (sw_q),
        .go_wr  (go_wr),
        .go_rd  (go_rd)
    );

    turnaround_timer #(
        .CNT_W(TA_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (go_wr || go_rd),
        .load_val(go_wr ? TA_W'(RTW_CYC) : TA_W'(WTR_CYC)),
        .busy    (busy)
    );

    assign mode_write   = (mode == MODE_WR);
    assign switch_pulse = sw_q;
    assign blocked      = busy;

    a_r7_gap_starts_with_pulse: assert property (@(posedge clk) disable iff (rst)
        switch_pulse |-> blocked);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        switch_pulse |=> !switch_pulse);
    a_r7_rtw_gap_len: assert property (@(posedge clk) disable iff (rst)
        (switch_pulse && mode_write) |=> (blocked == (RTW_CYC > 1)));
endmodule

// File: tb/rw_drain_sched_bench.sv
module rw_drain_sched_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] rd_count = '0;
    logic [6:0] wr_count = '0;
    logic       burst_issued = 1'b0;
    logic       mode_write;
    logic       switch_pulse;
    logic       blocked;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rw_drain_sched u_rw_drain_sched (
        .clk         (clk),
        .rst         (rst),
        .rd_count    (rd_count),
        .wr_count    (wr_count),
        .burst_issued(burst_issued),
        .mode_write  (mode_write),
        .switch_pulse(switch_pulse),
        .blocked     (blocked)
    );

    typedef struct packed {
        logic [5:0] rd;
        logic [6:0] wr;
        logic       b;
        logic       m;
        logic       s;
        logic       k;
    } vec_t;

    // Walked from reset; outputs checked one edge after each row is applied.
    localparam int NV = 16;
    localparam vec_t TBL [0:NV-1] = '{
        '{6'd5, 7'd54, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 54 is below high mark
        '{6'd0, 7'd31, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 idle below low mark
        '{6'd1, 7'd40, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 reads pending
        '{6'd0, 7'd32, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 low mark, reads empty
        '{6'd0, 7'd32, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 gap 2 cycles, R8 burst ignored
        '{6'd0, 7'd32, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 burst ignored
        '{6'd0, 7'd32, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 counted
        '{6'd0, 7'd32, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 counted
        '{6'd0, 7'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // R5 empty queue ends drain, R6
        '{6'd0, 7'd60, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 R8 gap of 6
        '{6'd0, 7'd60, 1'b0, 1'b0, 1'b0, 1'b1},
        '{6'd0, 7'd60, 1'b0, 1'b0, 1'b0, 1'b1},
        '{6'd0, 7'd60, 1'b0, 1'b0, 1'b0, 1'b1},
        '{6'd0, 7'd60, 1'b0, 1'b0, 1'b0, 1'b1},
        '{6'd0, 7'd60, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 gap over
        '{6'd3, 7'd60, 1'b0, 1'b1, 1'b1, 1'b1}  // R2 high mark with reads pending
    };

    task automatic chk(input string req, input logic em, input logic es, input logic ek);
        checks++;
        if (mode_write !== em || switch_pulse !== es || blocked !== ek) begin
            errors++;
            $display("FAIL %s: got mode=%b sw=%b blk=%b expected mode=%b sw=%b blk=%b",
                     req, mode_write, switch_pulse, blocked, em, es, ek);
        end
    endtask

    task automatic step(input logic [5:0] r, input logic [6:0] w, input logic b);
        rd_count     = r;
        wr_count     = w;
        burst_issued = b;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R9 reset state", 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].rd, TBL[i].wr, TBL[i].b);
            chk($sformatf("R%0s table row %0d", (i < 3) ? "4" : "7", i), TBL[i].m, TBL[i].s, TBL[i].k);
        end

        // Now in write mode with a 2-cycle gap; bursts in gap must not count (R8).
        step(6'd3, 7'd50, 1'b1);
        chk("R8 burst in gap", 1'b1, 1'b0, 1'b1);
        step(6'd3, 7'd50, 1'b1);
        chk("R8 burst in gap end", 1'b1, 1'b0, 1'b0);
        for (int n = 1; n <= 16; n++) begin
            step(6'd3, 7'd50, 1'b1);
            chk($sformatf("R5 minimum writes, burst %0d", n), 1'b1, 1'b0, 1'b0);
        end
        // 16 counted, no reads, above low mark: keep draining.
        step(6'd0, 7'd40, 1'b0);
        chk("R5 keep draining above low mark", 1'b1, 1'b0, 1'b0);
        step(6'd0, 7'd40, 1'b0);
        chk("R5 still draining", 1'b1, 1'b0, 1'b0);
        step(6'd0, 7'd31, 1'b0);
        chk("R5 below low mark returns to read", 1'b0, 1'b1, 1'b1);
        step(6'd0, 7'd31, 1'b0);
        chk("R6 pulse lasts one cycle", 1'b0, 1'b0, 1'b1);

        // Reset from write mode.
        repeat (6) step(6'd0, 7'd31, 1'b0);
        chk("R4 idle after gap", 1'b0, 1'b0, 1'b0);
        step(6'd2, 7'd64, 1'b0);
        chk("R2 full queue forces write", 1'b1, 1'b1, 1'b1);
        rst = 1'b1;
        step(6'd2, 7'd64, 1'b0);
        rst = 1'b0;
        chk("R9 reset from write mode", 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule